// File: doc/BRIEF.md
# Sliding 5x5 Window Summer

This block takes a raster stream of bytes, at most one per clock, each marked by an input strobe. Every accepted byte moves a two-dimensional window of byte registers forward by one position. The window is WIN rows by WIN columns, 5 by 5 by default. Row delay lines of parameterised length join each window row to the row below it, so the window always covers a square patch of an image that is ROW_LEN bytes wide. After each accepted byte the block reports the unsigned sum of all window entries. With 8-bit data that sum is 13 bits wide, and its largest possible value is 6375.

The sum comes from a balanced tree of two-input adders. Each level of the tree is only as wide as the worst-case partial sum it can carry. When a level has an odd operand left over, that operand passes through to the next level, zero-extended. A parameter can add pipeline registers after the first PIPE_STAGES tree levels. A value of 0 gives a purely combinational tree. The valid flag and the window-full flag travel through the same number of stages, so they stay aligned with the sum they describe.

Top module: `boxsum_5x5`

## Requirements
- R1: While rst_ni is low and after release before any accepted byte, sum_o is 0, sum_vld_o is 0 and win_full_o is 0. Reset also clears every window entry and every row delay to zero.
- R2: For each accepted byte, sum_o carries the unsigned sum of all WIN*WIN window entries present after that byte has shifted in.
- R3: While byte_vld_i is low the window does not move. Once the pipeline has drained, sum_o holds its value and sum_vld_o stays 0.
- R4: After the n-th accepted byte, the entry in row r, column c (r, c from 0) is the byte accepted r*ROW_LEN + c strobes earlier, or zero if no such byte exists since reset.
- R5: sum_vld_o pulses exactly once per accepted byte. The pulse comes 1 + PIPE_STAGES clock edges after the edge that samples byte_vld_i high, with PIPE_STAGES = 0 giving a combinational tree.
- R6: The full-scale sum, with all window entries equal to 2^DATA_W - 1 (6375 for the 5x5, 8-bit case), appears exactly with no overflow.
- R7: win_full_o stays 0 until (WIN-1)*ROW_LEN + WIN bytes have been accepted since reset. From the sum of that byte onward it is 1 until the next reset, aligned with sum_vld_o.
- R8: Every window position contributes with weight one, including the last operand, which has no partner at the first tree level.
- R9: Bytes on consecutive clock cycles are all accepted, and each yields its own correct sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Strobe: byte_i is accepted on this edge |
| byte_i | input | DATA_W | Incoming byte |
| sum_o | output | SUM_W | Sum of the window entries (13 bits by default) |
| sum_vld_o | output | 1 | One-cycle pulse marking a new sum |
| win_full_o | output | 1 | All window entries come from real bytes, aligned with sum_o |

## Verification
The bench builds two copies with ROW_LEN = 6: one with PIPE_STAGES = 2 and one with PIPE_STAGES = 0. The short row length makes the window fill after only 29 bytes. This lets a single impulse walk through every window position and every row delay, and the fill boundary and the full-scale sum can be reached many times within a short run. Running the combinational and the pipelined tree side by side on the same stream checks the latency and the flag alignment against the same arithmetic reference window.

// File: rtl/boxsum_pkg.sv
package boxsum_pkg;

  // number of pairwise levels to reduce n operands to one
  function automatic int num_lvls(input int n);
    int k;
    int l;
    k = n;
    l = 0;
    while (k > 1) begin
      k = (k + 1) / 2;
      l++;
    end
    return l;
  endfunction

  // operand count at tree level l
  function automatic int lvl_cnt(input int n, input int l);
    int k;
    k = n;
    for (int i = 0; i < l; i++) k = (k + 1) / 2;
    return k;
  endfunction

  // width needed for the worst-case partial sum at level l
  function automatic int lvl_w(input int n, input int dw, input int l);
    longint m;
    longint mx;
    m = longint'(1) << l;
    if (m > n) m = n;
    mx = m * ((longint'(1) << dw) - 1);
    return $clog2(mx + 1);
  endfunction

endpackage

// File: rtl/boxsum_line_delay.sv
module boxsum_line_delay #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DEPTH-1:0][DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (en_i) begin
      sr_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[DEPTH-1];

endmodule

// File: rtl/boxsum_window.sv
module boxsum_window #(
  parameter int DATA_W  = 8,
  parameter int WIN     = 5,
  parameter int ROW_LEN = 32,
  localparam int FILL   = (WIN - 1) * ROW_LEN + WIN,
  localparam int CNT_W  = $clog2(FILL + 1)
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   shift_i,
  input  logic [DATA_W-1:0]                      data_i,
  output logic [WIN-1:0][WIN-1:0][DATA_W-1:0]    win_o,
  output logic                                   full_o
);

  localparam int GAP = ROW_LEN - WIN;

  logic [WIN-1:0][WIN-1:0][DATA_W-1:0] win_q;
  logic [WIN-1:0][DATA_W-1:0]          row_in;
  logic [CNT_W-1:0]                    fill_q;

  assign row_in[0] = data_i;

  // row r is fed by the tail of row r-1 after GAP further bytes
  for (genvar r = 1; r < WIN; r++) begin : g_link
    if (GAP == 0) begin : g_direct
      assign row_in[r] = win_q[r-1][WIN-1];
    end else begin : g_delay
      boxsum_line_delay #(
        .DATA_W(DATA_W),
        .DEPTH (GAP)
      ) u_dly (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (shift_i),
        .d_i   (win_q[r-1][WIN-1]),
        .q_o   (row_in[r])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else if (shift_i) begin
      for (int r = 0; r < WIN; r++) begin
        win_q[r][0] <= row_in[r];
        for (int c = 1; c < WIN; c++) win_q[r][c] <= win_q[r][c-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                fill_q <= '0;
    else if (shift_i && fill_q != CNT_W'(FILL)) fill_q <= fill_q + 1'b1;
  end

  assign win_o  = win_q;
  assign full_o = (fill_q == CNT_W'(FILL));

  a_r3_hold_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(win_q));

  a_r4_newest_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> win_q[0][0] == $past(data_i));

  a_r7_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> full_o);

  a_r7_full_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(shift_i));

endmodule

// File: rtl/boxsum_tree.sv
module boxsum_tree
  import boxsum_pkg::*;
#(
  parameter int N      = 25,
  parameter int DATA_W = 8,
  parameter int PIPE   = 0,
  localparam int NLVL  = num_lvls(N),
  localparam int SUM_W = lvl_w(N, DATA_W, NLVL)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N*DATA_W-1:0]   ops_i,
  output logic [SUM_W-1:0]      sum_o
);

  localparam longint SUM_MAX = longint'(N) * ((longint'(1) << DATA_W) - 1);

  for (genvar l = 0; l <= NLVL; l++) begin : lv
    localparam int CNT = lvl_cnt(N, l);
    localparam int W   = lvl_w(N, DATA_W, l);
    logic [W-1:0] v [CNT];

    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < CNT; i++) begin : g_op
        assign v[i] = ops_i[i*DATA_W +: DATA_W];
      end
    end else begin : g_node
      localparam int PCNT = lvl_cnt(N, l - 1);
      logic [W-1:0] s [CNT];

      for (genvar i = 0; i < CNT; i++) begin : g_add
        if (2 * i + 1 < PCNT) begin : g_pair
          assign s[i] = W'(lv[l-1].v[2*i]) + W'(lv[l-1].v[2*i+1]);
        end else begin : g_pass
          assign s[i] = W'(lv[l-1].v[2*i]);
        end
      end

      if (l <= PIPE) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            for (int i = 0; i < CNT; i++) v[i] <= '0;
          end else begin
            for (int i = 0; i < CNT; i++) v[i] <= s[i];
          end
        end
      end else begin : g_wire
        for (genvar i = 0; i < CNT; i++) begin : g_w
          assign v[i] = s[i];
        end
      end
    end
  end

  assign sum_o = lv[NLVL].v[0];

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    longint'(sum_o) <= SUM_MAX);

endmodule

// File: rtl/boxsum_5x5.sv
module boxsum_5x5
  import boxsum_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int WIN         = 5,
  parameter int ROW_LEN     = 32,
  parameter int PIPE_STAGES = 2,
  localparam int N_OPS      = WIN * WIN,
  localparam int SUM_W      = lvl_w(N_OPS, DATA_W, num_lvls(N_OPS))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [SUM_W-1:0]  sum_o,
  output logic              sum_vld_o,
  output logic              win_full_o
);

  localparam int NLVL     = num_lvls(N_OPS);
  localparam int PIPE_EFF = (PIPE_STAGES > NLVL) ? NLVL : PIPE_STAGES;

  logic [WIN-1:0][WIN-1:0][DATA_W-1:0] win;
  logic [N_OPS*DATA_W-1:0]             ops;
  logic                                full;
  logic [PIPE_EFF:0]                   vld_p;
  logic [PIPE_EFF:0]                   full_p;

  boxsum_window #(
    .DATA_W (DATA_W),
    .WIN    (WIN),
    .ROW_LEN(ROW_LEN)
  ) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(byte_vld_i),
    .data_i (byte_i),
    .win_o  (win),
    .full_o (full)
  );

  assign ops = win;

  boxsum_tree #(
    .N     (N_OPS),
    .DATA_W(DATA_W),
    .PIPE  (PIPE_EFF)
  ) u_tree (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ops_i (ops),
    .sum_o (sum_o)
  );

  // stage 0: window has just moved; flags follow the tree registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_p[0] <= 1'b0;
    else         vld_p[0] <= byte_vld_i;
  end
  assign full_p[0] = full;

  for (genvar s = 1; s <= PIPE_EFF; s++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_p[s]  <= 1'b0;
        full_p[s] <= 1'b0;
      end else begin
        vld_p[s]  <= vld_p[s-1];
        full_p[s] <= full_p[s-1];
      end
    end
  end

  assign sum_vld_o  = vld_p[PIPE_EFF];
  assign win_full_o = full_p[PIPE_EFF];

  if (PIPE_EFF == 0) begin : g_comb_chk
    a_r5_comb_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_vld_i |=> sum_vld_o);
    a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !byte_vld_i |=> !sum_vld_o);
  end

endmodule

// File: tb/tb_boxsum_5x5.sv
`timescale 1ns/1ps
module tb_boxsum_5x5;

  localparam int DW   = 8;
  localparam int WIN  = 5;
  localparam int RL   = 6;
  localparam int PP   = 2;
  localparam int FILL = (WIN - 1) * RL + WIN;
  localparam int MAXB = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [7:0] data = '0;

  logic [12:0] sum_p, sum_c;
  logic        vld_p, vld_c, full_p, full_c;

  always #5 clk = ~clk;

  boxsum_5x5 #(.DATA_W(DW), .WIN(WIN), .ROW_LEN(RL), .PIPE_STAGES(PP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(strobe), .byte_i(data),
    .sum_o(sum_p), .sum_vld_o(vld_p), .win_full_o(full_p));

  boxsum_5x5 #(.DATA_W(DW), .WIN(WIN), .ROW_LEN(RL), .PIPE_STAGES(0)) dut_comb (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(strobe), .byte_i(data),
    .sum_o(sum_c), .sum_vld_o(vld_c), .win_full_o(full_c));

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    n_acc  = 0;
  int    n_ep   = 0;
  int    rd_p   = 0;
  int    rd_c   = 0;
  bit    done   = 0;
  string cur_req = "R2";

  int hist    [MAXB];
  int exp_sum [MAXB];
  bit exp_full[MAXB];
  int acc_cyc [MAXB];

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference window model
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n && strobe && n_acc < MAXB) begin
      int s;
      hist[n_acc] = int'(data);
      s = 0;
      for (int r = 0; r < WIN; r++)
        for (int c = 0; c < WIN; c++)
          if (r * RL + c <= n_ep) s += hist[n_acc - (r * RL + c)];
      exp_sum[n_acc]  = s;
      exp_full[n_acc] = (n_ep + 1 >= FILL);
      acc_cyc[n_acc]  = cyc;
      n_acc++;
      n_ep++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && vld_p) begin
      if (rd_p >= n_acc) chk("R5", 1, 0, "pipelined spurious valid");
      else begin
        chk(cur_req, int'(sum_p), exp_sum[rd_p], "pipelined sum");
        chk("R7", int'(full_p), int'(exp_full[rd_p]), "pipelined full flag");
        chk("R5", cyc - acc_cyc[rd_p], PP, "pipelined latency");
        rd_p++;
      end
    end
    if (rst_n && vld_c) begin
      if (rd_c >= n_acc) chk("R5", 1, 0, "comb spurious valid");
      else begin
        chk(cur_req, int'(sum_c), exp_sum[rd_c], "comb sum");
        chk("R7", int'(full_c), int'(exp_full[rd_c]), "comb full flag");
        chk("R5", cyc - acc_cyc[rd_c], 0, "comb latency");
        rd_c++;
      end
    end
  end

  task automatic send(input logic [7:0] b, input int gap);
    strobe = 1'b1;
    data   = b;
    @(negedge clk);
    strobe = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic check_reset_state(input string req);
    chk(req, int'(sum_p), 0, "sum after reset");
    chk(req, int'(sum_c), 0, "comb sum after reset");
    chk(req, int'(vld_p) + int'(vld_c), 0, "valid after reset");
    chk(req, int'(full_p) + int'(full_c), 0, "full after reset");
  endtask

  initial begin
    logic [15:0] lfsr;
    int          held_p, held_c;
    lfsr = 16'hACE1;

    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("R1");

    // impulse walks through every position and row delay
    cur_req = "R4";
    send(8'd1, 0);
    for (int i = 0; i < 34; i++) send(8'd0, 0);
    repeat (4) @(negedge clk);

    // last operand alone (no first-level partner)
    cur_req = "R8";
    for (int i = 0; i < FILL; i++) send((i == 0) ? 8'd77 : 8'd0, 0);
    repeat (4) @(negedge clk);
    chk("R8", int'(sum_p), 77, "last-position operand only");

    // irregular traffic with gaps
    cur_req = "R2";
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr[7:0], int'(lfsr[9:8]));
    end
    repeat (4) @(negedge clk);

    // idle: nothing moves
    held_p = int'(sum_p);
    held_c = int'(sum_c);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R3", int'(sum_p), held_p, "held sum");
      chk("R3", int'(sum_c), held_c, "comb held sum");
      chk("R3", int'(vld_p) + int'(vld_c), 0, "valid while idle");
    end

    // full scale
    cur_req = "R6";
    for (int i = 0; i < 40; i++) send(8'hFF, 0);
    repeat (4) @(negedge clk);
    chk("R6", int'(sum_p), 6375, "full-scale sum");
    chk("R6", int'(sum_c), 6375, "comb full-scale sum");

    // second reset, then fill boundary
    chk("R5", rd_p, n_acc, "pipelined valid count before reset");
    chk("R5", rd_c, n_acc, "comb valid count before reset");
    rst_n = 1'b0;
    n_ep  = 0;
    @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R7";
    for (int i = 0; i < FILL - 1; i++) send(8'(i + 3), 0);
    repeat (4) @(negedge clk);
    chk("R7", int'(full_p) + int'(full_c), 0, "not full one byte short");
    send(8'd9, 0);
    repeat (4) @(negedge clk);
    chk("R7", int'(full_p) + int'(full_c), 2, "full at fill count");

    // back-to-back ramp
    cur_req = "R9";
    for (int i = 0; i < 100; i++) send(8'(i * 7 + 1), 0);
    repeat (6) @(negedge clk);

    chk("R5", rd_p, n_acc, "pipelined valid count");
    chk("R5", rd_c, n_acc, "comb valid count");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule